// File: doc/BRIEF.md
# Tiny Accumulator Stored-Program Core

This block is a complete, very small 32-bit processor built around one accumulator. Its main store of 32 words, each 32 bits, sits inside the block. A 5-bit program counter steps through the store. Each clock cycle in which the core runs fetches one instruction and executes it. The core decodes eight function codes: an indirect jump, a relative jump, a negated load, a store, two codes that both subtract, a skip taken when the accumulator is negative, and a halt.

Before a program runs, a host port loads it word by word. After a run, the same port reads any word back. The host port is honoured only while the core is idle, meaning the run enable is low or the core has halted. Inside the store every word is held with its bit order reversed, and the core reverses the bits again on every read and write. As a result, the host port, the fetch path and the operand path all work with the logical word. The program counter, the accumulator and the halt flag are brought out as outputs for observation.

Top module: `tiny_acc_core`

## Requirements
- R1: An instruction is the logical (un-reversed) store word. Bits 15:13 hold the function code and bits 4:0 hold the operand address. All other bits are ignored.
- R2: While reset is asserted (rst_n low), the PC becomes 1, the accumulator becomes 0 and the halt flag becomes 0. The store keeps its contents.
- R3: While the core is idle, a host write puts host_wdata into the word at host_addr, and host_rdata always shows the logical word at host_addr. A host write while the core is running and not halted has no effect.
- R4: Each executed instruction first advances the PC by one, modulo 32, so 31 wraps to 0.
- R5: While run_en is low, the PC, the accumulator, the halt flag and the store do not change.
- R6: Function 0 sets the PC to the low 5 bits of the operand word plus one.
- R7: Function 7 sets the halt flag, leaving the PC one past the halt instruction. From then until reset, the PC, the accumulator and the store hold their values.
- R8: Function 2 loads the accumulator with the two's-complement negation of the operand word.
- R9: Function 3 writes the accumulator into the operand address.
- R10: Functions 4 and 5 both subtract the operand word from the accumulator.
- R11: Function 1 adds the operand word, as a signed value, to the already advanced PC, modulo 32.
- R12: Function 6 advances the PC by a further one when the accumulator's sign bit is set. Otherwise it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Executes one instruction per cycle while high |
| host_we | input | 1 | Host write strobe, honoured only while idle |
| host_addr | input | 5 | Host store address |
| host_wdata | input | 32 | Host write data (logical word) |
| host_rdata | output | 32 | Logical word at host_addr, combinational |
| pc_o | output | 5 | Program counter |
| acc_o | output | 32 | Accumulator |
| halted_o | output | 1 | Halt flag |

## Verification
The PC, the accumulator and the halt flag are registers, so each reflects an instruction one rising edge after the core samples run_en high with that instruction at the PC. A store write made by the core or the host becomes visible on host_rdata in the same step. The bench raises run_en at a falling edge and counts executed instructions as rising edges. It then compares the outputs at the following falling edge, checking intermediate PC and accumulator values after each chosen step, not only the state after the core halts. Host reads are combinational and are sampled one time unit after the address settles, with the core idle.

// File: rtl/tac_pkg.sv
package tac_pkg;
   typedef enum logic [2:0] {
      FN_JUMP_IND = 3'd0,
      FN_JUMP_REL = 3'd1,
      FN_LOAD_NEG = 3'd2,
      FN_STORE    = 3'd3,
      FN_SUB_A    = 3'd4,
      FN_SUB_B    = 3'd5,
      FN_SKIP_NEG = 3'd6,
      FN_HALT     = 3'd7
   } fn_e;

   localparam int FN_W = 3;
endpackage

// File: rtl/tac_bitrev.sv
module tac_bitrev #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/tac_store.sv
module tac_store #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter bit REVERSED = 1'b1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [DATA_W-1:0] fetch_data,
   input  logic [ADDR_W-1:0] opnd_addr,
   output logic [DATA_W-1:0] opnd_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] wr_phys, fetch_phys, opnd_phys, peek_phys;

   assign fetch_phys = cells[fetch_addr];
   assign opnd_phys  = cells[opnd_addr];
   assign peek_phys  = cells[peek_addr];

   if (REVERSED) begin : g_rev
      tac_bitrev #(.W(DATA_W)) u_rev_wr    (.din(wr_data),    .dout(wr_phys));
      tac_bitrev #(.W(DATA_W)) u_rev_fetch (.din(fetch_phys), .dout(fetch_data));
      tac_bitrev #(.W(DATA_W)) u_rev_opnd  (.din(opnd_phys),  .dout(opnd_data));
      tac_bitrev #(.W(DATA_W)) u_rev_peek  (.din(peek_phys),  .dout(peek_data));
   end else begin : g_plain
      assign wr_phys    = wr_data;
      assign fetch_data = fetch_phys;
      assign opnd_data  = opnd_phys;
      assign peek_data  = peek_phys;
   end

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_phys;
   end
endmodule

// File: rtl/tac_exec.sv
module tac_exec
   import tac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] acc,
   input  fn_e               fn,
   input  logic [DATA_W-1:0] opnd,
   output logic [ADDR_W-1:0] pc_nxt,
   output logic [DATA_W-1:0] acc_nxt,
   output logic              halt_set,
   output logic              store_en
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic [ADDR_W-1:0] pc_inc;
   assign pc_inc = pc + ONE_A;

   always_comb begin
      pc_nxt   = pc_inc;
      acc_nxt  = acc;
      halt_set = 1'b0;
      store_en = 1'b0;
      unique case (fn)
         FN_JUMP_IND: pc_nxt  = opnd[ADDR_W-1:0] + ONE_A;
         FN_JUMP_REL: pc_nxt  = pc_inc + opnd[ADDR_W-1:0];
         FN_LOAD_NEG: acc_nxt = '0 - opnd;
         FN_STORE:    store_en = 1'b1;
         FN_SUB_A,
         FN_SUB_B:    acc_nxt = acc - opnd;
         FN_SKIP_NEG: if (acc[DATA_W-1]) pc_nxt = pc_inc + ONE_A;
         FN_HALT:     halt_set = 1'b1;
         default:     ;
      endcase
   end
endmodule

// File: rtl/tiny_acc_core.sv
module tiny_acc_core
   import tac_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int FN_LSB   = 13,
   parameter int RESET_PC = 1,
   parameter bit REVERSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              halted_o
);
   localparam int DEPTH = 1 << ADDR_W;

   if (FN_LSB + FN_W > DATA_W) begin : g_err_fn
      $error("function field does not fit in the word");
   end
   if (ADDR_W > FN_LSB) begin : g_err_ovl
      $error("operand field overlaps function field");
   end
   if (RESET_PC >= DEPTH) begin : g_err_pc
      $error("reset PC outside the store");
   end

   logic [ADDR_W-1:0] pc_q, pc_nxt;
   logic [DATA_W-1:0] acc_q, acc_nxt;
   logic              halt_q, halt_set, store_en;
   logic              stepping;
   logic [DATA_W-1:0] instr_word, opnd_word;
   logic [ADDR_W-1:0] opnd_addr;
   fn_e               dec_fn;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   assign stepping  = run_en && !halt_q;
   assign opnd_addr = instr_word[ADDR_W-1:0];
   assign dec_fn    = fn_e'(instr_word[FN_LSB +: FN_W]);

   assign wr_en   = stepping ? store_en  : host_we;
   assign wr_addr = stepping ? opnd_addr : host_addr;
   assign wr_data = stepping ? acc_q     : host_wdata;

   tac_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REVERSED(REVERSED)) u_store (
      .clk        (clk),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .fetch_addr (pc_q),
      .fetch_data (instr_word),
      .opnd_addr  (opnd_addr),
      .opnd_data  (opnd_word),
      .peek_addr  (host_addr),
      .peek_data  (host_rdata)
   );

   tac_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exec (
      .pc       (pc_q),
      .acc      (acc_q),
      .fn       (dec_fn),
      .opnd     (opnd_word),
      .pc_nxt   (pc_nxt),
      .acc_nxt  (acc_nxt),
      .halt_set (halt_set),
      .store_en (store_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= ADDR_W'(RESET_PC);
         acc_q  <= '0;
         halt_q <= 1'b0;
      end else if (stepping) begin
         pc_q  <= pc_nxt;
         acc_q <= acc_nxt;
         if (halt_set) halt_q <= 1'b1;
      end
   end

   assign pc_o     = pc_q;
   assign acc_o    = acc_q;
   assign halted_o = halt_q;
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int RESET_PC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              halted,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] acc,
   input logic [2:0]        fn,
   input logic [DATA_W-1:0] opnd
);
   logic step;
   assign step = run_en && !halted;

   assert_reset_state_R2: assert property (@(posedge clk)
      !rst_n |=> (pc == ADDR_W'(RESET_PC) && acc == '0 && !halted));

   assert_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !halted) |=> ($stable(pc) && $stable(acc) && !halted));

   assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc) && $stable(acc)));

   assert_halt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && fn == 3'd7) |=> halted);

   assert_seq_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (fn == 3'd2 || fn == 3'd3 || fn == 3'd4 || fn == 3'd5 || fn == 3'd7))
      |=> (pc == $past(pc) + ADDR_W'(1)));

   assert_load_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && fn == 3'd2) |=> (acc == '0 - $past(opnd)));
endmodule

bind tiny_acc_core tac_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run_en (run_en),
   .halted (halted_o),
   .pc     (pc_o),
   .acc    (acc_o),
   .fn     (instr_word[FN_LSB +: 3]),
   .opnd   (opnd_word)
);

// File: tb/tiny_acc_core_tb.sv
module tiny_acc_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        host_we = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [4:0]  pc_o;
   logic [31:0] acc_o;
   logic        halted_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   tiny_acc_core u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .pc_o(pc_o), .acc_o(acc_o), .halted_o(halted_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] enc(input int fn, input int addr);
      return (32'(fn) << 13) | 32'(addr);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hwr(input int a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hrd(input int a, output logic [31:0] d);
      host_addr = 5'(a);
      #1 d = host_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      run_en = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_steps(input int n);
      run_en = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      chk("R2 pc", 32'(pc_o), 32'd1);
      chk("R2 acc", acc_o, 32'd0);
      chk("R2 halt", 32'(halted_o), 32'd0);
      hwr(9, 32'hA5C3_0F81);
      hrd(9, d);
      chk("R3 host readback", d, 32'hA5C3_0F81);
   endtask

   task automatic t_arith();
      logic [31:0] d;
      do_reset();
      hwr(1, enc(2, 20)); hwr(2, enc(4, 21)); hwr(3, enc(5, 21));
      hwr(4, enc(3, 22)); hwr(5, enc(7, 0));
      hwr(20, 32'd5); hwr(21, 32'd3); hwr(22, 32'h0);
      run_steps(1);
      chk("R4 pc step", 32'(pc_o), 32'd2);
      chk("R8 negate", acc_o, -32'sd5);
      run_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 pc paused", 32'(pc_o), 32'd2);
      chk("R5 acc paused", acc_o, -32'sd5);
      run_steps(1);
      chk("R10 sub code 4", acc_o, -32'sd8);
      run_steps(1);
      chk("R10 sub code 5", acc_o, -32'sd11);
      run_steps(2);
      chk("R7 halted", 32'(halted_o), 32'd1);
      chk("R7 pc past halt", 32'(pc_o), 32'd6);
      run_steps(3);
      chk("R7 pc frozen", 32'(pc_o), 32'd6);
      chk("R7 acc frozen", acc_o, -32'sd11);
      hrd(22, d);
      chk("R9 stored acc", d, -32'sd11);
      run_en = 1'b0;
   endtask

   task automatic t_jumps();
      do_reset();
      hwr(1, enc(0, 20)); hwr(20, 32'd9);
      hwr(10, enc(1, 21)); hwr(21, 32'hFFFF_FFFD);
      hwr(8, enc(7, 0));
      run_steps(1);
      chk("R6 indirect jump", 32'(pc_o), 32'd10);
      run_steps(1);
      chk("R11 relative back", 32'(pc_o), 32'd8);
      run_steps(1);
      chk("R7 halt after jumps", 32'(halted_o), 32'd1);
      chk("R7 pc after jumps", 32'(pc_o), 32'd9);
      run_en = 1'b0;
   endtask

   task automatic t_skip();
      do_reset();
      hwr(1, enc(2, 20)); hwr(20, 32'd1);
      hwr(2, enc(6, 0)); hwr(3, enc(7, 0));
      hwr(4, enc(2, 21)); hwr(21, 32'hFFFF_FFF9);
      hwr(5, enc(6, 0)); hwr(6, enc(7, 0));
      run_steps(2);
      chk("R12 skip taken", 32'(pc_o), 32'd4);
      chk("R12 skip taken halt", 32'(halted_o), 32'd0);
      run_steps(2);
      chk("R12 no skip", 32'(pc_o), 32'd6);
      chk("R8 negate negative", acc_o, 32'd7);
      run_steps(1);
      chk("R7 halt pc", 32'(pc_o), 32'd7);
      run_en = 1'b0;
   endtask

   task automatic t_wrap();
      do_reset();
      hwr(1, enc(0, 20)); hwr(20, 32'd30);
      hwr(31, enc(6, 0));
      hwr(0, 32'hFFFF_FFE0);
      run_steps(1);
      chk("R6 jump to 31", 32'(pc_o), 32'd31);
      run_steps(1);
      chk("R4 wrap to 0", 32'(pc_o), 32'd0);
      run_steps(1);
      chk("R1 ignored bits halt", 32'(halted_o), 32'd1);
      chk("R1 pc after halt", 32'(pc_o), 32'd1);
      run_en = 1'b0;
   endtask

   task automatic t_host_block();
      logic [31:0] d;
      do_reset();
      hwr(1, enc(1, 20)); hwr(20, 32'hFFFF_FFFF);
      hwr(21, 32'h11);
      run_en = 1'b1;
      @(negedge clk);
      host_we = 1'b1; host_addr = 5'd21; host_wdata = 32'h55;
      @(negedge clk);
      host_we = 1'b0;
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      chk("R11 self loop pc", 32'(pc_o), 32'd1);
      hrd(21, d);
      chk("R3 write while running ignored", d, 32'h11);
      hwr(21, 32'h66);
      hrd(21, d);
      chk("R3 write while idle", d, 32'h66);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_jumps();
      t_skip();
      t_wrap();
      t_host_block();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule